// File: doc/BRIEF.md
# Clock-Strobed Path Delay Digitizer

This controller digitizes the propagation delay of paths through a combinational unit under test. For each path it runs a sweep of trials. A trial asks an external phase shifter to move the capture clock to a given step and waits for the acknowledge. It then fires the launch row once, so that a single rising or falling transition enters the unit. Finally it inspects the capture flop of the selected output. The capture counts as successful when that flop's data input and its output agree, which means their XOR is zero. The first step index that gives a successful capture is the delay of that sample, in units of one phase step.

The phase step restarts at zero for every sample. Each path is measured 1, 2, 4, 8 or 16 times. The samples are summed at full width and scaled to an unsigned value in 12.4 fixed point, and that value is written to an internal result memory. The memory holds the group of rising-transition paths followed by the group of falling-transition paths. If a sweep reaches the last permitted step without a capture, the entry is written with a saturated value and an error flag. A start pulse begins a run over both groups. A busy level frames the run, and a one-cycle done pulse ends it. After the run, entries are read through a combinational read port.

Top module: `pdly_sweep_top`

## Requirements
- R1: After reset, busy_o, done_o, phase_req_o and launch_o are all 0; while idle, no phase request and no launch is issued.
- R2: Each trial holds phase_req_o with a stable phase_step_o until phase_ack_i is seen. launch_o then pulses for one cycle, in the cycle after the acknowledge. launch_o and phase_req_o are never high together.
- R3: The first trial of every sample requests step 0. Each trial that fails requests the previous step plus one.
- R4: The output examined is bit (path_o mod OUT_W) of cap_d_i/cap_q_i, sampled when cap_vld_i is high. Success means that bit of cap_d_i equals that bit of cap_q_i. All other bits have no effect.
- R5: A sample's delay is the step index of the first successful trial in its sweep.
- R6: samples_log2_i is latched at start. Values 0..4 select N = 2^value samples per path, and any value above 4 is treated as 4. The stored word is sum_of_delays * 16 / N: an unsigned 16-bit value with 4 fractional bits.
- R7: If the trial at step MAX_STEP fails, the path ends at once, with no further trials and no further samples. Its entry is written as word 16'h7FFF with rd_err_o = 1, and no request ever exceeds MAX_STEP.
- R8: Rising paths (rising_o = 1) are measured first, in path order 0..PATHS-1, and stored at addresses 0..PATHS-1. Falling paths follow in the same order at addresses PATHS..2*PATHS-1. Entries without errors read rd_err_o = 0.
- R9: busy_o rises in the cycle after start_i is accepted in idle. done_o pulses for one cycle at the end of the run, and busy_o is low in the following cycle. start_i while busy has no effect.
- R10: rd_word_o/rd_err_o show the entry at rd_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a full measurement run |
| samples_log2_i | input | 3 | log2 of samples per path (clamped to 4) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| phase_req_o | output | 1 | Phase step request to the shifter |
| phase_step_o | output | STEP_W | Requested capture phase step |
| phase_ack_i | input | 1 | Shifter has settled at the requested step |
| launch_o | output | 1 | Fire the launch row once |
| rising_o | output | 1 | Current group: 1 rising, 0 falling |
| path_o | output | PATH_W | Current path index within the group |
| cap_vld_i | input | 1 | Capture row values valid for this trial |
| cap_d_i | input | OUT_W | Capture flop data inputs |
| cap_q_i | input | OUT_W | Capture flop outputs |
| rd_addr_i | input | ADDR_W | Result memory read address |
| rd_word_o | output | 16 | Stored 12.4 delay word |
| rd_err_o | output | 1 | Stored no-capture error flag |

## Verification
The checker watches the trial handshake on every cycle. It checks that the request stays stable until the acknowledge, that a launch follows only an acknowledge, and that a request and a launch never overlap. It also checks that the phase ceiling is never crossed, that the path stays stable during a trial, that the block is quiet while idle, and that the done pulse has the right shape. The bench's scenarios are the only source of evidence for the values that land in memory: the ordering of the step sequence, the fixed-point average for each sample count, the clamping of the sample exponent, and the selection of the output bit against decoy bits that agree or disagree. The same holds for the memory placement of the two groups, the saturation and early end of a path with no capture, and the fact that a start while busy is ignored.

// File: rtl/pdly_pkg.sv
package pdly_pkg;
  localparam int WORD_W = 16;
  localparam int FRAC_W = 4;
  localparam int KMAX   = 4;
  localparam logic [WORD_W-1:0] SAT_WORD = 16'h7FFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_LAUNCH,
    S_WAIT,
    S_WRITE,
    S_DONE
  } sweep_state_e;
endpackage

// File: rtl/pdly_cap_check.sv
module pdly_cap_check #(
  parameter int OUT_W = 64,
  localparam int SEL_W = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
  input  logic [OUT_W-1:0] cap_d_i,
  input  logic [OUT_W-1:0] cap_q_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  logic [OUT_W-1:0] diff;
  assign diff  = cap_d_i ^ cap_q_i;
  assign hit_o = ~diff[sel_i];
endmodule

// File: rtl/pdly_accum.sv
module pdly_accum
  import pdly_pkg::*;
#(
  parameter int STEP_W = 11,
  localparam int SUM_W = STEP_W + KMAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [STEP_W-1:0] val_i,
  input  logic [2:0]        k_i,
  output logic [WORD_W-1:0] word_o
);
  logic [SUM_W-1:0] sum_q;
  logic [31:0]      scaled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_q + SUM_W'(val_i);
  end

  // sum * 2^FRAC_W / 2^k, exact since k <= FRAC_W
  always_comb begin
    scaled = (32'(sum_q) << FRAC_W) >> k_i;
    word_o = scaled[WORD_W-1:0];
  end
endmodule

// File: rtl/pdly_result_mem.sv
module pdly_result_mem
  import pdly_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wword_i,
  input  logic              werr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rword_o,
  output logic              rerr_o
);
  logic [WORD_W:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= {werr_i, wword_i};
  end

  assign {rerr_o, rword_o} = mem_q[raddr_i];
endmodule

// File: rtl/pdly_sweep_top.sv
module pdly_sweep_top
  import pdly_pkg::*;
#(
  parameter int PATHS    = 256,
  parameter int OUT_W    = 64,
  parameter int MAX_STEP = 2047,
  localparam int STEP_W  = $clog2(MAX_STEP + 1),
  localparam int PATH_W  = $clog2(PATHS),
  localparam int ADDR_W  = $clog2(2 * PATHS),
  localparam int SEL_W   = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        samples_log2_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              phase_req_o,
  output logic [STEP_W-1:0] phase_step_o,
  input  logic              phase_ack_i,
  output logic              launch_o,
  output logic              rising_o,
  output logic [PATH_W-1:0] path_o,
  input  logic              cap_vld_i,
  input  logic [OUT_W-1:0]  cap_d_i,
  input  logic [OUT_W-1:0]  cap_q_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              rd_err_o
);
  sweep_state_e      state_q, state_d;
  logic [PATH_W-1:0] path_q;
  logic              fall_q;
  logic [4:0]        samp_q;
  logic [STEP_W-1:0] step_q;
  logic [2:0]        k_q;
  logic              err_q;

  logic              hit;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] acc_word;
  logic              last_samp, last_step, last_path;
  logic              trial_end, acc_add, acc_clr, mem_we;
  logic [ADDR_W-1:0] waddr;
  logic [WORD_W-1:0] wword;

  assign sel       = SEL_W'(32'(path_q) % OUT_W);
  assign last_samp = (samp_q == 5'((1 << k_q) - 1));
  assign last_step = (step_q == STEP_W'(MAX_STEP));
  assign last_path = (path_q == PATH_W'(PATHS - 1)) && fall_q;
  assign trial_end = (state_q == S_WAIT) && cap_vld_i;
  assign acc_add   = trial_end && hit;
  assign acc_clr   = (state_q == S_WRITE) || (state_q == S_IDLE);
  assign mem_we    = (state_q == S_WRITE);
  assign waddr     = ADDR_W'(fall_q ? PATHS + 32'(path_q) : 32'(path_q));
  assign wword     = err_q ? SAT_WORD : acc_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_REQ;
      S_REQ:    if (phase_ack_i) state_d = S_LAUNCH;
      S_LAUNCH: state_d = S_WAIT;
      S_WAIT: begin
        if (cap_vld_i) begin
          if (hit) state_d = last_samp ? S_WRITE : S_REQ;
          else     state_d = last_step ? S_WRITE : S_REQ;
        end
      end
      S_WRITE:  state_d = last_path ? S_DONE : S_REQ;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      path_q  <= '0;
      fall_q  <= 1'b0;
      samp_q  <= '0;
      step_q  <= '0;
      k_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          k_q    <= (samples_log2_i > 3'(KMAX)) ? 3'(KMAX) : samples_log2_i;
          path_q <= '0;
          fall_q <= 1'b0;
          samp_q <= '0;
          step_q <= '0;
          err_q  <= 1'b0;
        end
        S_WAIT: if (cap_vld_i) begin
          if (hit) begin
            step_q <= '0;
            samp_q <= samp_q + 5'd1;
          end else if (last_step) begin
            err_q  <= 1'b1;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        S_WRITE: begin
          samp_q <= '0;
          step_q <= '0;
          err_q  <= 1'b0;
          if (path_q == PATH_W'(PATHS - 1)) begin
            path_q <= '0;
            fall_q <= 1'b1;
          end else begin
            path_q <= path_q + PATH_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign phase_req_o  = (state_q == S_REQ);
  assign phase_step_o = step_q;
  assign launch_o     = (state_q == S_LAUNCH);
  assign rising_o     = ~fall_q;
  assign path_o       = path_q;

  pdly_cap_check #(.OUT_W(OUT_W)) u_cap (
    .cap_d_i (cap_d_i),
    .cap_q_i (cap_q_i),
    .sel_i   (sel),
    .hit_o   (hit)
  );

  pdly_accum #(.STEP_W(STEP_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .val_i  (step_q),
    .k_i    (k_q),
    .word_o (acc_word)
  );

  pdly_result_mem #(.DEPTH(2 * PATHS)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wword_i (wword),
    .werr_i  (err_q),
    .raddr_i (rd_addr_i),
    .rword_o (rd_word_o),
    .rerr_o  (rd_err_o)
  );
endmodule

// File: rtl/pdly_sweep_chk.sv
module pdly_sweep_chk #(
  parameter int MAX_STEP = 2047,
  parameter int STEP_W   = 11,
  parameter int PATH_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              phase_req_o,
  input logic [STEP_W-1:0] phase_step_o,
  input logic              phase_ack_i,
  input logic              launch_o,
  input logic              rising_o,
  input logic [PATH_W-1:0] path_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!phase_req_o && !launch_o));

  p_launch_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> $past(phase_req_o && phase_ack_i));

  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_req_o && launch_o));

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_req_o && !phase_ack_i) |=> (phase_req_o && $stable(phase_step_o)));

  p_step_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_req_o |-> (32'(phase_step_o) <= MAX_STEP));

  p_path_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> ($stable(path_o) && $stable(rising_o)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

bind pdly_sweep_top pdly_sweep_chk #(
  .MAX_STEP (MAX_STEP),
  .STEP_W   (STEP_W),
  .PATH_W   (PATH_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .phase_req_o  (phase_req_o),
  .phase_step_o (phase_step_o),
  .phase_ack_i  (phase_ack_i),
  .launch_o     (launch_o),
  .rising_o     (rising_o),
  .path_o       (path_o)
);

// File: tb/pdly_sweep_top_test.sv
`timescale 1ns/1ps
module pdly_sweep_top_test;
  localparam int PATHS    = 4;
  localparam int OUT_W    = 4;
  localparam int MAX_STEP = 24;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);
  localparam int PATH_W   = $clog2(PATHS);
  localparam int ADDR_W   = $clog2(2 * PATHS);

  // run table: {samples_log2 applied, effective N}
  localparam logic [7:0] RUNS [6] = '{
    {3'd0, 5'd1}, {3'd1, 5'd2}, {3'd2, 5'd4},
    {3'd3, 5'd8}, {3'd4, 5'd16}, {3'd6, 5'd16}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] samples_log2_i = '0;
  logic busy_o, done_o, phase_req_o, launch_o, rising_o, rd_err_o;
  logic [STEP_W-1:0] phase_step_o;
  logic phase_ack_i = 1'b0;
  logic [PATH_W-1:0] path_o;
  logic cap_vld_i = 1'b0;
  logic [OUT_W-1:0] cap_d_i = '0, cap_q_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [15:0] rd_word_o;

  int n_chk = 0, n_fail = 0;
  int succ [2][PATHS];
  int launches [2][PATHS];
  int step_viol = 0, exp_step = 0, cur_phase = 0, ack_wait = 0, trial_cnt = 0;
  int done_cnt = 0;
  logic pend_cap = 1'b0;
  int cap_e = 0, cap_p = 0;

  always #2.5 clk_i = ~clk_i;

  pdly_sweep_top #(.PATHS(PATHS), .OUT_W(OUT_W), .MAX_STEP(MAX_STEP)) uut (
    .clk_i, .rst_ni, .start_i, .samples_log2_i, .busy_o, .done_o,
    .phase_req_o, .phase_step_o, .phase_ack_i, .launch_o, .rising_o, .path_o,
    .cap_vld_i, .cap_d_i, .cap_q_i, .rd_addr_i, .rd_word_o, .rd_err_o
  );

  function automatic int base_dly(int e, int p);
    if (e == 0) return (p == 3) ? 40 : 3 + 3 * p;
    return 5 + 2 * p;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic clear_stub();
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < PATHS; p++) begin
        succ[e][p] = 0;
        launches[e][p] = 0;
      end
    step_viol = 0;
    exp_step = 0;
  endtask

  // behavioural phase shifter and unit under test
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) done_cnt++;
      phase_ack_i = 1'b0;
      cap_vld_i = 1'b0;
      if (pend_cap) begin
        int s, sel;
        bit hitb;
        s = succ[cap_e][cap_p];
        hitb = (cur_phase >= base_dly(cap_e, cap_p) + (s & 1));
        sel = cap_p % OUT_W;
        cap_d_i = (cap_e == 0) ? '1 : '0;
        cap_q_i = ~cap_d_i;                       // decoy bits disagree
        cap_q_i[(sel + 1) % OUT_W] = cap_d_i[(sel + 1) % OUT_W]; // one decoy agrees
        cap_q_i[sel] = hitb ? cap_d_i[sel] : ~cap_d_i[sel];
        cap_vld_i = 1'b1;
        if (hitb) succ[cap_e][cap_p]++;
        exp_step = (hitb || cur_phase == MAX_STEP) ? 0 : cur_phase + 1;
        pend_cap = 1'b0;
      end
      if (launch_o) begin
        cap_e = rising_o ? 0 : 1;
        cap_p = int'(path_o);
        launches[cap_e][cap_p]++;
        pend_cap = 1'b1;
      end
      if (phase_req_o) begin
        if (ack_wait == 0) begin
          phase_ack_i = 1'b1;
          cur_phase = int'(phase_step_o);
          if (cur_phase != exp_step) step_viol++;
          trial_cnt++;
          ack_wait = trial_cnt % 3;
        end else ack_wait--;
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 40000; c++) begin
      @(negedge clk_i);
      if (done_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_and_check(logic [2:0] kin, int n, bit busy_start);
    bit ok;
    int half;
    clear_stub();
    @(negedge clk_i);
    samples_log2_i = kin;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    if (busy_start) begin
      repeat (20) @(negedge clk_i);
      samples_log2_i = 3'd4;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R9 done reached", int'(ok), 1);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R9 idle after done", int'(busy_o), 0);
    chk(step_viol == 0, "R3 step sequence", step_viol, 0);
    half = (n > 1) ? 8 : 0;
    for (int a = 0; a < 2 * PATHS; a++) begin
      int e, p, expw, experr;
      e = a / PATHS;
      p = a % PATHS;
      rd_addr_i = ADDR_W'(a);
      #1;
      if (base_dly(e, p) > MAX_STEP) begin
        expw = 16'h7FFF;
        experr = 1;
        chk(rd_word_o == 16'(expw), "R7 saturated word", int'(rd_word_o), expw);
        chk(launches[e][p] == MAX_STEP + 1, "R7 trials stop at ceiling", launches[e][p], MAX_STEP + 1);
      end else begin
        expw = base_dly(e, p) * 16 + half;
        experr = 0;
        chk(rd_word_o == 16'(expw), "R6 R5 R4 R8 averaged word", int'(rd_word_o), expw);
      end
      chk(int'(rd_err_o) == experr, "R8 R7 error flag", int'(rd_err_o), experr);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_stub();
    #12;
    chk(busy_o == 0 && done_o == 0, "R1 reset busy/done", int'({busy_o, done_o}), 0);
    chk(phase_req_o == 0 && launch_o == 0, "R1 reset req/launch", int'({phase_req_o, launch_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && phase_req_o == 0, "R1 idle quiet", int'({busy_o, phase_req_o}), 0);

    foreach (RUNS[i]) begin
      run_and_check(RUNS[i][7:5], int'(RUNS[i][4:0]), 1'b0);
    end

    // start while busy: run must keep N=1 results and end once (R9)
    done_cnt = 0;
    run_and_check(3'd0, 1, 1'b1);
    repeat (60) @(negedge clk_i);
    chk(done_cnt == 1, "R9 start ignored while busy", done_cnt, 1);
    chk(busy_o == 0, "R9 no second run", int'(busy_o), 0);

    // R10: read port follows address combinationally
    rd_addr_i = ADDR_W'(PATHS);
    #1;
    chk(rd_word_o == 16'(5 * 16), "R10 read falling path 0", int'(rd_word_o), 80);
    rd_addr_i = ADDR_W'(1);
    #1;
    chk(rd_word_o == 16'(6 * 16), "R10 read rising path 1", int'(rd_word_o), 96);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule